// File: doc/BRIEF.md
# Edge Interrupt Cause Unit

This block watches a bank of GPIO input pins and turns chosen signal transitions into interrupt requests. Each pin is first passed through a multi-flop synchronizer. A transition is found by comparing the synchronized value with the value one clock earlier. Two independent per-pin masks choose which transitions count: one for low-to-high and one for high-to-low. A qualifying transition sets a sticky cause bit, and that bit stays set until software acknowledges it.

A separate per-pin event mask decides which stored causes reach the processor. The masked causes are ORed into one registered, active-high interrupt line. That line can be wired to an interrupt input shared with other sources. Software reads the masked pending set from one register offset. It acknowledges events by writing ones to a clear offset.

Top module: `gpio_edge_irq`

## Requirements
- R1: The low-to-high mask is written and read back at offset 0x44. When its bit n is 1, a 0-to-1 change on synchronized pin n sets cause bit n.
- R2: The high-to-low mask is written and read back at offset 0x48. When its bit n is 1, a 1-to-0 change on synchronized pin n sets cause bit n.
- R3: A cause bit becomes 1 only in the cycle after an enabled transition on its pin. With both masks set, a transition in either direction sets the bit. With neither mask set, no transition sets it.
- R4: A read at offset 0x80 returns the cause bits ANDed with the event mask. Writes to 0x80 change nothing.
- R5: The event mask is written and read back at offset 0x94. Clearing an event-mask bit hides that cause bit without erasing it, so setting the mask bit again makes the cause visible again.
- R6: Writing to offset 0x98 clears every cause bit whose data bit is 1. Cause bits whose data bit is 0 keep their value.
- R7: If a clear and a new enabled transition hit the same cause bit in the same cycle, the bit ends up set.
- R8: `irq_out` is a flop. It is 1 exactly one cycle after any bit of (cause AND event mask) is 1, and 0 one cycle after none is.
- R9: After reset, all three masks and all causes are 0 and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| irq_out | output | 1 | Registered interrupt request, active high |

## Verification
The acknowledge write and a fresh enabled transition can land on the same cause bit in the same clock. The bench sets up a stored cause on two pins. It then moves one of those pins so that its detected transition is present exactly in the cycle where a clear of both bits is captured. It counts every register stage between the pin and the cause bit to place that write. The bit with the new transition must stay pending, and its neighbour, which has no transition, must clear. A second overlap is a change to the event mask while a cause is stored: the bench checks that the interrupt line follows one cycle later and that the hidden cause returns when the mask bit is set again.

// File: rtl/gei_pkg.sv
// Shared constants for the edge interrupt cause unit: register offsets and widths.
package gei_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] OFF_RISE_EN = 8'h44;
    localparam logic [REG_AW-1:0] OFF_FALL_EN = 8'h48;
    localparam logic [REG_AW-1:0] OFF_PENDING = 8'h80;
    localparam logic [REG_AW-1:0] OFF_EVT_EN  = 8'h94;
    localparam logic [REG_AW-1:0] OFF_CLEAR   = 8'h98;
endpackage

// File: rtl/gei_sync.sv
// Multi-flop synchronizer for a pin vector. It also keeps the synchronized value
// from the previous clock. Assumes each pin changes slowly compared with clk.
module gei_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_now,
    output logic [W-1:0] q_prev
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    // Shift the raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    // Keep the last synchronized value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[LAST];
    end

    assign q_now  = chain[LAST];
    assign q_prev = prev_q;
endmodule

// File: rtl/gei_edge.sv
// Per-pin transition qualifier. It compares the current and previous synchronized
// levels against the low-to-high and high-to-low masks. Purely combinational.
module gei_edge #(
    parameter int W = 32
) (
    input  logic [W-1:0] now_lvl,
    input  logic [W-1:0] prev_lvl,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] edge_hit
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic went_up, went_down;
        // Classify the transition of pin g, then qualify it with its masks.
        assign went_up     = now_lvl[g] & ~prev_lvl[g];
        assign went_down   = ~now_lvl[g] & prev_lvl[g];
        assign edge_hit[g] = (went_up & rise_en[g]) | (went_down & fall_en[g]);
    end
endmodule

// File: rtl/gei_cause.sv
// Sticky cause store. Qualified edges set bits and a write-one clear resets them.
// An edge arriving in the same cycle as a clear takes priority.
module gei_cause #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] edge_hit,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] cause
);
    logic [W-1:0] cause_q;
    logic [W-1:0] clr_eff;

    // Apply the clear mask only while a clear write is active.
    assign clr_eff = clr_en ? clr_mask : '0;

    // Clear first, then OR in new edges so that edges win.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_eff) | edge_hit;
    end

    assign cause = cause_q;
endmodule

// File: rtl/gpio_edge_irq.sv
// Edge interrupt cause unit for a GPIO bank. It holds the three masks, decodes
// register reads and writes, and registers the combined interrupt line.
// Assumes single-cycle write strobes and a combinational read of reg_addr.
module gpio_edge_irq
    import gei_pkg::*;
#(
    parameter int NPINS       = REG_DW,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic              irq_out
);
    localparam int PAD = REG_DW - NPINS;

    logic [NPINS-1:0] rise_en_q, fall_en_q, evt_en_q;
    logic [NPINS-1:0] lvl_now, lvl_prev;
    logic [NPINS-1:0] edge_hit;
    logic [NPINS-1:0] cause_q;
    logic [NPINS-1:0] pending;
    logic             clr_wr;
    logic             irq_q;

    gei_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q_now  (lvl_now),
        .q_prev (lvl_prev)
    );

    gei_edge #(.W(NPINS)) u_edge (
        .now_lvl  (lvl_now),
        .prev_lvl (lvl_prev),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .edge_hit (edge_hit)
    );

    assign clr_wr = reg_wen && (reg_addr == OFF_CLEAR);

    gei_cause #(.W(NPINS)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .clr_en   (clr_wr),
        .clr_mask (reg_wdata[NPINS-1:0]),
        .cause    (cause_q)
    );

    // Write the three mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
            evt_en_q  <= '0;
        end else if (reg_wen) begin
            case (reg_addr)
                OFF_RISE_EN: rise_en_q <= reg_wdata[NPINS-1:0];
                OFF_FALL_EN: fall_en_q <= reg_wdata[NPINS-1:0];
                OFF_EVT_EN:  evt_en_q  <= reg_wdata[NPINS-1:0];
                default: ;
            endcase
        end
    end

    assign pending = cause_q & evt_en_q;

    // Read mux; zero-extends when the bank is narrower than the bus.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_RISE_EN: reg_rdata = REG_DW'({{PAD{1'b0}}, rise_en_q});
            OFF_FALL_EN: reg_rdata = REG_DW'({{PAD{1'b0}}, fall_en_q});
            OFF_EVT_EN:  reg_rdata = REG_DW'({{PAD{1'b0}}, evt_en_q});
            OFF_PENDING: reg_rdata = REG_DW'({{PAD{1'b0}}, pending});
            default:     reg_rdata = '0;
        endcase
    end

    // Register the OR of pending causes so the shared line cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pending;
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/gei_checker.sv
// Temporal properties of the edge interrupt cause unit. Bound to gpio_edge_irq.
module gei_checker
    import gei_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wen,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic [W-1:0]      cause,
    input logic [W-1:0]      evt_en,
    input logic [W-1:0]      edge_hit,
    input logic              irq_out
);
    // R3: a cause bit rises only where an enabled edge was seen.
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause & ~$past(cause) & ~$past(edge_hit)) == '0));

    // R6: bits named by a clear write with no edge are zero afterwards.
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == OFF_CLEAR) |=>
        ((cause & $past(reg_wdata[W-1:0]) & ~$past(edge_hit)) == '0));

    // R7: an edge coincident with a clear leaves its bit set.
    p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == OFF_CLEAR) |=>
        ((cause & $past(edge_hit)) == $past(edge_hit)));

    // R8: the line tracks the masked causes one cycle later.
    p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(cause & evt_en))));

    // R9: first cycle out of reset is quiet.
    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cause == '0 && !irq_out));
endmodule

bind gpio_edge_irq gei_checker #(.W(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cause     (cause_q),
    .evt_en    (evt_en_q),
    .edge_hit  (edge_hit),
    .irq_out   (irq_out)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
    import gei_pkg::*;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 6;

    typedef struct packed {
        logic [31:0] rise, fall, evt, from, to, exp;
    } vec_t;

    // Transition table: masks, start and end pin levels, expected pending word.
    localparam vec_t VEC [NV] = '{
        '{32'h0000_00FF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0F0F, 32'h0000_000F}, // R1
        '{32'h0000_0000, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'hFF00_0000}, // R2
        '{32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000, 32'hF0F0_0F0F}, // R1 R2
        '{32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_00F0, 32'h0000_00AA, 32'h0000_0055, 32'h0000_00F0}, // R3 R4
        '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}, // R3
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_irq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] v;
        do_reset();
        // R9: reset state.
        rd(OFF_PENDING, v); check("R9 pending", v, 32'h0);
        check("R9 irq", {31'b0, irq_out}, 32'h0);
        rd(OFF_RISE_EN, v); check("R9 rise mask", v, 32'h0);
        rd(OFF_EVT_EN, v);  check("R9 event mask", v, 32'h0);

        // Table walk covering R1 R2 R3 R4 R5 R8.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk) pin_in = VEC[i].from;
            settle();
            wr(OFF_RISE_EN, VEC[i].rise);
            wr(OFF_FALL_EN, VEC[i].fall);
            wr(OFF_EVT_EN,  VEC[i].evt);
            wr(OFF_CLEAR,   32'hFFFF_FFFF);
            @(negedge clk) pin_in = VEC[i].to;
            settle();
            rd(OFF_PENDING, v);
            check($sformatf("R1/R2/R3/R4 vector %0d pending", i), v, VEC[i].exp);
            check($sformatf("R8 vector %0d irq", i), {31'b0, irq_out}, {31'b0, |VEC[i].exp});
        end
        rd(OFF_FALL_EN, v); check("R2 fall mask readback", v, 32'h0);
        rd(OFF_RISE_EN, v); check("R1 rise mask readback", v, 32'hFFFF_FFFF);

        // R5: masking hides a cause and unmasking shows it again.
        wr(OFF_CLEAR, 32'hFFFF_FFFF);
        @(negedge clk) pin_in = 32'h0;
        settle();
        wr(OFF_EVT_EN, 32'hFFFF_FFFF);
        wr(OFF_CLEAR, 32'hFFFF_FFFF);
        @(negedge clk) pin_in = 32'h0000_00F0;
        settle();
        rd(OFF_PENDING, v); check("R1 set F0", v, 32'h0000_00F0);
        wr(OFF_EVT_EN, 32'h0);
        settle();
        rd(OFF_PENDING, v); check("R5 masked pending", v, 32'h0);
        check("R5 masked irq", {31'b0, irq_out}, 32'h0);
        wr(OFF_EVT_EN, 32'hFFFF_FFFF);
        settle();
        rd(OFF_EVT_EN, v);  check("R5 event mask readback", v, 32'hFFFF_FFFF);
        rd(OFF_PENDING, v); check("R5 unmasked pending", v, 32'h0000_00F0);

        // R4: a write to the pending view is ignored.
        wr(OFF_PENDING, 32'h0);
        settle();
        rd(OFF_PENDING, v); check("R4 write ignored", v, 32'h0000_00F0);

        // R6: partial write-one clear.
        wr(OFF_CLEAR, 32'h0000_0030);
        rd(OFF_PENDING, v); check("R6 partial clear", v, 32'h0000_00C0);

        // R8: irq is one cycle behind the pending view.
        wr(OFF_EVT_EN, 32'h0);
        settle();
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = OFF_EVT_EN; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        reg_wen = 1'b0; reg_addr = OFF_PENDING;
        #1;
        check("R8 pending visible", reg_rdata, 32'h0000_00C0);
        check("R8 irq not yet", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        #1 check("R8 irq one cycle later", {31'b0, irq_out}, 32'h1);

        // R7: falling edge on pin 7 collides with a clear of pins 6 and 7.
        wr(OFF_FALL_EN, 32'hFFFF_FFFF);
        settle();
        @(negedge clk) pin_in = 32'h0000_0070;
        @(posedge clk);
        @(posedge clk);
        wr(OFF_CLEAR, 32'h0000_00C0);
        rd(OFF_PENDING, v); check("R7 edge wins over clear", v, 32'h0000_0080);

        // R9: reset in mid-run clears everything.
        do_reset();
        rd(OFF_PENDING, v); check("R9 pending after reset", v, 32'h0);
        check("R9 irq after reset", {31'b0, irq_out}, 32'h0);
        rd(OFF_FALL_EN, v); check("R9 fall mask after reset", v, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule